// File: doc/BRIEF.md
# Sequenced calibration register bank

This block stores ten 14-bit calibration words: one gain word, one offset word and eight DAC trim words. Software reaches all of them through a single 16-bit data port. It does not address the words directly. An internal pointer walks a fixed order and moves on by itself after each access. The order is gain (index 0), offset (index 1), then DAC trim 1 through DAC trim 8 (indices 2 to 9).

A control write chooses a subset code and a readback select value. The subset code decides which words the pointer visits and where it starts. The readback select value decides whether later data-port accesses are reads or writes. When the last word of the subset has been accessed, the pointer goes back to the start of the subset and a one-cycle done pulse is raised. Software can abandon a sequence part way through; the next control write rewinds the pointer.

A separate load port lets an on-chip calibration engine write any word directly. It takes priority over a software write to the same word in the same cycle.

Top module: `calreg_seq_bank`

## Requirements
- R1: After reset, the gain and offset words hold 0x2000 and all DAC words hold 0x0000. `dp_rdata` and `seq_done` read 0, the bank is in write mode, the subset code is 00 and the pointer is at gain.
- R2: Subset code 00 visits all ten words in order: gain (0), offset (1), DAC 1 (2) through DAC 8 (9).
- R3: Subset code 01 visits gain and then offset, and then starts again at gain.
- R4: Subset code 10 visits only the offset word. Subset code 11 visits only the gain word. In both cases every access is the final access of its sequence.
- R5: Every control write puts the pointer at the start of the new subset: offset for code 10, gain for every other code. This applies even when a sequence was left unfinished.
- R6: The access that completes a sequence puts the pointer back at the subset start. It also sets `seq_done` high for exactly the following cycle.
- R7: A control write with `cfg_rdsel` = 2'b10 selects read mode. In read mode, a `dp_rd` pulse loads `dp_rdata` with {2'b00, word} in the cycle after the strobe. Bits [15:14] of `dp_rdata` are always 0.
- R8: In read mode, `dp_wr` changes no word and does not move the pointer. In write mode (any other `cfg_rdsel`), `dp_rd` leaves `dp_rdata` unchanged and does not move the pointer.
- R9: Bits [15:14] of `dp_wdata` are discarded. Only bits [13:0] are stored.
- R10: When `dp_rd` and `dp_wr` are both high, the access is handled as a write and the read is dropped, so `dp_rdata` is unchanged.
- R11: `ld_en` writes `ld_data` into word `ld_idx`. If a software write targets the same word in the same cycle, the load value wins. The software write still counts as an access.
- R12: A data-port strobe in the same cycle as `cfg_we` is dropped. It changes no word and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_subset | input | 2 | Subset code latched on `cfg_we` |
| cfg_rdsel | input | 2 | Readback select; 2'b10 selects read mode |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| ld_en | input | 1 | Calibration engine load strobe |
| ld_idx | input | 4 | Index of the word to load (0 to 9) |
| ld_data | input | 14 | Value to load |
| dp_rdata | output | 16 | Read data, zero-padded |
| seq_done | output | 1 | One-cycle pulse after the final access of a sequence |

## Verification
The assertions assume that `ld_idx` always lies in the range 0 to 9. They also assume that each strobe lasts one cycle and that reset is held for several clock edges with every strobe low. The stimulus drives every strobe for exactly one clock and returns it to 0. It loads only valid indices. It always issues a control write before changing mode or subset, so the pointer position the bench expects is always known.

// File: rtl/calreg_pkg.sv
package calreg_pkg;
   typedef enum logic [1:0] {
      SUB_ALL  = 2'b00,
      SUB_PAIR = 2'b01,
      SUB_OFF  = 2'b10,
      SUB_GAIN = 2'b11
   } subset_e;

   localparam logic [1:0] RDSEL_CAL = 2'b10;
   localparam int unsigned IDX_GAIN = 0;
   localparam int unsigned IDX_OFF  = 1;
endpackage

// File: rtl/calreg_ptr.sv
module calreg_ptr
   import calreg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 10,
   parameter int unsigned IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_subset,
   input  logic             acc_go,
   output logic [IDX_W-1:0] ptr,
   output logic             done
);
   subset_e sub_q;

   function automatic logic [IDX_W-1:0] start_of(input subset_e s);
      return (s == SUB_OFF) ? IDX_W'(IDX_OFF) : IDX_W'(IDX_GAIN);
   endfunction

   function automatic logic [IDX_W-1:0] last_of(input subset_e s);
      case (s)
         SUB_ALL:  return IDX_W'(NUM_REGS - 1);
         SUB_PAIR: return IDX_W'(IDX_OFF);
         SUB_OFF:  return IDX_W'(IDX_OFF);
         default:  return IDX_W'(IDX_GAIN);
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_q <= SUB_ALL;
         ptr   <= IDX_W'(IDX_GAIN);
         done  <= 1'b0;
      end else if (cfg_we) begin
         sub_q <= subset_e'(cfg_subset);
         ptr   <= start_of(subset_e'(cfg_subset));
         done  <= 1'b0;
      end else if (acc_go) begin
         if (ptr == last_of(sub_q)) begin
            ptr  <= start_of(sub_q);
            done <= 1'b1;
         end else begin
            ptr  <= ptr + 1'b1;
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assert_ptr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr >= start_of(sub_q)) && (ptr <= last_of(sub_q)));

   assert_cfg_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> (ptr == start_of(sub_q)));

   assert_done_rewound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ptr == start_of(sub_q)));
endmodule

// File: rtl/calreg_store.sv
module calreg_store #(
   parameter int unsigned NUM_REGS = 10,
   parameter int unsigned DATA_W   = 14,
   parameter int unsigned IDX_W    = 4,
   parameter logic [DATA_W-1:0] GAIN_RST = 14'h2000,
   parameter logic [DATA_W-1:0] OFF_RST  = 14'h2000,
   parameter logic [DATA_W-1:0] DAC_RST  = 14'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] words [NUM_REGS]
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      localparam logic [DATA_W-1:0] RST_VAL =
         (i == 0) ? GAIN_RST : ((i == 1) ? OFF_RST : DAC_RST);
      logic ld_hit, wr_hit;
      assign ld_hit = ld_en && (ld_idx == IDX_W'(i));
      assign wr_hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)      words[i] <= RST_VAL;
         else if (ld_hit) words[i] <= ld_data;
         else if (wr_hit) words[i] <= wr_data;
      end

      assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ld_en && (ld_idx == IDX_W'(i))) |-> (words[i] == $past(ld_data)));
   end
endmodule

// File: rtl/calreg_seq_bank.sv
module calreg_seq_bank
   import calreg_pkg::*;
#(
   parameter int unsigned NUM_DAC  = 8,
   parameter int unsigned DATA_W   = 14,
   parameter int unsigned PORT_W   = 16,
   parameter logic [DATA_W-1:0] GAIN_RST = 14'h2000,
   parameter logic [DATA_W-1:0] OFF_RST  = 14'h2000,
   parameter logic [DATA_W-1:0] DAC_RST  = 14'h0000,
   localparam int unsigned NUM_REGS = NUM_DAC + 2,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS),
   localparam int unsigned PAD_W    = PORT_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_subset,
   input  logic [1:0]        cfg_rdsel,
   input  logic              dp_rd,
   input  logic              dp_wr,
   input  logic [PORT_W-1:0] dp_wdata,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   output logic [PORT_W-1:0] dp_rdata,
   output logic              seq_done
);
   if (PORT_W <= DATA_W) begin : g_bad_width
      $error("PORT_W must exceed DATA_W");
   end
   if (NUM_DAC < 1) begin : g_bad_depth
      $error("NUM_DAC must be at least 1");
   end

   logic             rd_mode_q;
   logic             wr_go, rd_go, acc_go;
   logic [IDX_W-1:0] ptr;
   logic [DATA_W-1:0] words [NUM_REGS];
   logic             unused_pad;

   assign unused_pad = ^dp_wdata[PORT_W-1:DATA_W];

   // A control write blocks data-port strobes; a write strobe masks a read.
   assign wr_go  = !cfg_we && dp_wr && !rd_mode_q;
   assign rd_go  = !cfg_we && dp_rd && !dp_wr && rd_mode_q;
   assign acc_go = wr_go || rd_go;

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_mode_q <= 1'b0;
      else if (cfg_we) rd_mode_q <= (cfg_rdsel == RDSEL_CAL);
   end

   calreg_ptr #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_subset(cfg_subset),
      .acc_go(acc_go), .ptr(ptr), .done(seq_done)
   );

   calreg_store #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .GAIN_RST(GAIN_RST), .OFF_RST(OFF_RST), .DAC_RST(DAC_RST)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .wr_idx(ptr),
      .wr_data(dp_wdata[DATA_W-1:0]), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_data(ld_data), .words(words)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     dp_rdata <= '0;
      else if (rd_go) dp_rdata <= {{PAD_W{1'b0}}, words[ptr]};
   end

   assert_rdata_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dp_rdata[PORT_W-1:DATA_W] == '0);

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mode_q |=> $stable(dp_rdata));

   assert_both_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd && dp_wr) |=> $stable(dp_rdata));
endmodule

// File: tb/calreg_seq_bank_bench.sv
`timescale 1ns/1ps
module calreg_seq_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_subset = 2'b00;
   logic [1:0]  cfg_rdsel = 2'b00;
   logic        dp_rd = 1'b0;
   logic        dp_wr = 1'b0;
   logic [15:0] dp_wdata = '0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_idx = '0;
   logic [13:0] ld_data = '0;
   logic [15:0] dp_rdata;
   logic        seq_done;

   int errors = 0;
   int checks = 0;
   logic [13:0] mdl [10];
   logic [15:0] exp_q [$];
   string       tag_q [$];
   logic [15:0] last_rd = '0;

   always #10 clk = ~clk;

   calreg_seq_bank u_calreg_seq_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_subset(cfg_subset),
      .cfg_rdsel(cfg_rdsel), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .dp_rdata(dp_rdata), .seq_done(seq_done)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected read word per completed read strobe.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(dp_rdata == e, t, dp_rdata, e);
      end
   end

   task automatic ctl(input logic [1:0] sub, input logic [1:0] rs,
                      input bit with_wr = 1'b0, input logic [15:0] wd = '0);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_subset = sub; cfg_rdsel = rs; dp_wr = with_wr; dp_wdata = wd;
      @(posedge clk); #1;
      cfg_we = 1'b0; dp_wr = 1'b0;
      chk(seq_done == 1'b0, "R12", {15'd0, seq_done}, 16'd0);
   endtask

   task automatic wr(input logic [15:0] d, input bit exp_done, input string req);
      @(posedge clk); #1;
      dp_wr = 1'b1; dp_wdata = d;
      @(posedge clk); #1;
      dp_wr = 1'b0;
      chk(seq_done == exp_done, req, {15'd0, seq_done}, {15'd0, exp_done});
   endtask

   task automatic rd(input logic [15:0] exp, input bit exp_done, input string req);
      @(posedge clk); #1;
      dp_rd = 1'b1;
      @(posedge clk); #1;
      dp_rd = 1'b0;
      chk(seq_done == exp_done, req, {15'd0, seq_done}, {15'd0, exp_done});
      exp_q.push_back(exp); tag_q.push_back(req);
      last_rd = exp;
   endtask

   task automatic both(input logic [15:0] d, input bit exp_done);
      @(posedge clk); #1;
      dp_rd = 1'b1; dp_wr = 1'b1; dp_wdata = d;
      @(posedge clk); #1;
      dp_rd = 1'b0; dp_wr = 1'b0;
      chk(seq_done == exp_done, "R10", {15'd0, seq_done}, {15'd0, exp_done});
      exp_q.push_back(last_rd); tag_q.push_back("R10");
   endtask

   task automatic load(input logic [3:0] idx, input logic [13:0] d,
                       input bit with_wr = 1'b0, input logic [15:0] wd = '0);
      @(posedge clk); #1;
      ld_en = 1'b1; ld_idx = idx; ld_data = d; dp_wr = with_wr; dp_wdata = wd;
      @(posedge clk); #1;
      ld_en = 1'b0; dp_wr = 1'b0;
      if (with_wr) chk(seq_done == 1'b1, "R11", {15'd0, seq_done}, 16'd1);
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      mdl[0] = 14'h2000; mdl[1] = 14'h2000;
      for (int i = 2; i < 10; i++) mdl[i] = 14'h0000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(dp_rdata == 16'h0000, "R1", dp_rdata, 16'h0000);
      chk(seq_done == 1'b0, "R1", {15'd0, seq_done}, 16'd0);

      // R1: reset contents, full walk in read mode
      ctl(2'b00, 2'b10);
      for (int i = 0; i < 10; i++) rd({2'b00, mdl[i]}, i == 9, "R1");

      // R2 / R9: write all ten with top bits set, read back, then rewind (R6)
      ctl(2'b00, 2'b00);
      for (int i = 0; i < 10; i++) begin
         logic [15:0] d;
         d = 16'hC000 | 16'(i * 16'h0123 + 16'h0011);
         wr(d, i == 9, "R2");
         mdl[i] = d[13:0];
      end
      ctl(2'b00, 2'b10);
      for (int i = 0; i < 10; i++) rd({2'b00, mdl[i]}, i == 9, "R9");
      rd({2'b00, mdl[0]}, 1'b0, "R6");

      // R3: gain then offset pair
      ctl(2'b01, 2'b00);
      wr(16'h1AAA, 1'b0, "R3"); mdl[0] = 14'h1AAA;
      wr(16'h2555, 1'b1, "R3"); mdl[1] = 14'h2555;
      ctl(2'b01, 2'b10);
      rd({2'b00, mdl[0]}, 1'b0, "R3");
      rd({2'b00, mdl[1]}, 1'b1, "R3");
      rd({2'b00, mdl[0]}, 1'b0, "R3");

      // R4: single-word subsets
      ctl(2'b10, 2'b00);
      wr(16'h0F0F, 1'b1, "R4");
      wr(16'h3C3C, 1'b1, "R4"); mdl[1] = 14'h3C3C;
      ctl(2'b10, 2'b10);
      rd({2'b00, mdl[1]}, 1'b1, "R4");
      rd({2'b00, mdl[1]}, 1'b1, "R4");
      ctl(2'b11, 2'b00);
      wr(16'h0123, 1'b1, "R4"); mdl[0] = 14'h0123;
      ctl(2'b11, 2'b10);
      rd({2'b00, mdl[0]}, 1'b1, "R4");

      // R5: abandon a sequence, control write rewinds
      ctl(2'b00, 2'b10);
      rd({2'b00, mdl[0]}, 1'b0, "R5");
      rd({2'b00, mdl[1]}, 1'b0, "R5");
      rd({2'b00, mdl[2]}, 1'b0, "R5");
      ctl(2'b00, 2'b10);
      rd({2'b00, mdl[0]}, 1'b0, "R5");

      // R8: write ignored in read mode, read ignored in write mode
      wr(16'h3FFF, 1'b0, "R8");
      rd({2'b00, mdl[1]}, 1'b0, "R8");
      ctl(2'b11, 2'b00);
      rd(last_rd, 1'b0, "R8");
      wr(16'h0777, 1'b1, "R8"); mdl[0] = 14'h0777;
      ctl(2'b11, 2'b10);
      rd({2'b00, mdl[0]}, 1'b1, "R8");

      // R10: both strobes act as a write
      ctl(2'b11, 2'b00);
      both(16'h1357, 1'b1); mdl[0] = 14'h1357;
      ctl(2'b11, 2'b10);
      rd({2'b00, mdl[0]}, 1'b1, "R10");

      // R11: load port wins over a same-word software write
      ctl(2'b11, 2'b00);
      load(4'd0, 14'h2468, 1'b1, 16'h0999); mdl[0] = 14'h2468;
      load(4'd1, 14'h1111); mdl[1] = 14'h1111;
      load(4'd9, 14'h3ABC); mdl[9] = 14'h3ABC;
      ctl(2'b00, 2'b10);
      for (int i = 0; i < 10; i++) rd({2'b00, mdl[i]}, i == 9, "R11");

      // R12: data strobe in the control-write cycle is dropped
      ctl(2'b11, 2'b00);
      ctl(2'b11, 2'b00, 1'b1, 16'h0555);
      ctl(2'b11, 2'b10);
      rd({2'b00, mdl[0]}, 1'b1, "R12");

      repeat (3) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule